// File: doc/BRIEF.md
# General-Purpose Pin Bank with Edge-Detect Interrupts

This block controls one bank of up to 32 general-purpose pins through a small word-addressed register port. Software programs which pins drive and which only sense. It changes the output latch through two write-only registers, one that raises bits and one that lowers them, so no read-modify-write cycle is needed. It reads the synchronized pad levels back at any time. A 2-bit function field per pin is held and presented to the surrounding pin multiplexer, which lies outside this block.

Every pad input passes through a synchronizer. The synchronized value is compared with its value one cycle earlier to find transitions. Each pin has its own rising-edge enable and falling-edge enable. Either or both may be on. A transition of an enabled polarity sets a sticky status bit, and software clears that bit by writing a one to it. Pins 0 and 1 each have a private interrupt line. The status bits of all higher pins are ORed onto one shared line.

Register map, using word addresses on `reg_addr`: 0 pin level (read only), 1 direction, 2 latch-set (write only), 3 latch-clear (write only), 4 rising enables, 5 falling enables, 6 edge status (write one to clear), 7 function fields for pins 0 to 15, 8 function fields for pins 16 to 31.

Top module: `gpio_edge_bank`

## Requirements
- R1: A write to address 2 sets `pad_out` high for every 1 bit of the write data. Latch bits whose data bit is 0 keep their value.
- R2: A write to address 3 sets `pad_out` low for every 1 bit of the write data. Latch bits whose data bit is 0 keep their value.
- R3: The direction register at address 1 reads back as written. `pad_oe` bit n is 1 (driving) exactly when direction bit n is 1, and follows a direction write on the next clock.
- R4: A read of address 0 returns the pad inputs after a two-flop synchronizer. This holds whether or not the pin is set to drive.
- R5: Status bit n at address 6 sets when synchronized pin n goes 0 to 1 while rising-enable bit n (address 4) is 1. It also sets when the pin goes 1 to 0 while falling-enable bit n (address 5) is 1. A transition of a disabled polarity leaves the bit unchanged, and both polarities may be enabled together. A pad change becomes visible in the status on the third clock edge after it.
- R6: A write to address 6 clears each status bit whose data bit is 1 and leaves the others unchanged. Writing back a value just read therefore clears exactly the events that were read.
- R7: `irq_pin0` equals status bit 0, and `irq_pin1` equals status bit 1. `irq_shared` is the OR of status bits 2 and above.
- R8: Pin n has a 2-bit function field. It is held at address 7 for pins 0 to 15 and at address 8 for pins 16 to 31, at bits 2*(n mod 16)+1 down to 2*(n mod 16), and is driven on `pin_func[2n+1:2n]`. The field reads back as written.
- R9: After reset the direction, output latch, rising enables, falling enables, edge status and all interrupt lines are 0.
- R10: When a new edge event and a clearing write reach the same status bit on the same clock edge, the bit remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pad_in | input | NUM_PINS | Pad input levels (asynchronous) |
| pad_out | output | NUM_PINS | Output latch toward the pads |
| pad_oe | output | NUM_PINS | Per-pin output-driver enable |
| pin_func | output | 2*NUM_PINS | Per-pin function selection fields |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_shared | output | 1 | Combined interrupt for pins 2 and above |

## Verification
The bench steps every pin through all four combinations of edge enables and drives one edge of each polarity. It checks that only the intended status bit sets and that only the matching interrupt line rises. A design that swapped polarities, leaked pins 0 and 1 into the shared line, or cleared every status bit on any write would fail here. Set and clear writes use overlapping masks, so a latch that wrote the whole word instead of only the 1 bits shows up at once. One clearing write is timed to land on the same edge as a new event, which catches a design that gives the write priority.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 4;
   localparam int FIELD_W = 2;
   localparam int PINS_PER_FUNC_WORD = DATA_W / FIELD_W;

   localparam logic [ADDR_W-1:0] A_LEVEL = 4'd0;
   localparam logic [ADDR_W-1:0] A_DIR = 4'd1;
   localparam logic [ADDR_W-1:0] A_SET = 4'd2;
   localparam logic [ADDR_W-1:0] A_CLR = 4'd3;
   localparam logic [ADDR_W-1:0] A_RISE = 4'd4;
   localparam logic [ADDR_W-1:0] A_FALL = 4'd5;
   localparam logic [ADDR_W-1:0] A_STAT = 4'd6;
   localparam logic [ADDR_W-1:0] A_FUNC0 = 4'd7;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int WIDTH = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_now,
   output logic [WIDTH-1:0] sync_prev
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_pin_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= async_in;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[s] <= '0;
         else        stage_q[s] <= stage_q[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_prev <= '0;
      else        sync_prev <= stage_q[STAGES-1];
   end

   assign sync_now = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sync_now,
   input  logic [WIDTH-1:0] sync_prev,
   input  logic [WIDTH-1:0] rise_en,
   input  logic [WIDTH-1:0] fall_en,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] status
);
   logic [WIDTH-1:0] hit;
   logic [WIDTH-1:0] keep;

   assign hit  = (sync_now & ~sync_prev & rise_en) | (~sync_now & sync_prev & fall_en);
   assign keep = clr_we ? (status & ~clr_mask) : status;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= keep | hit;
   end
endmodule

// File: rtl/gpio_func_regs.sv
module gpio_func_regs
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 32,
   localparam int WORDS = (NUM_PINS + PINS_PER_FUNC_WORD - 1) / PINS_PER_FUNC_WORD
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [WORDS-1:0]          word_we,
   input  logic [DATA_W-1:0]         wdata,
   output logic [FIELD_W*NUM_PINS-1:0] fields,
   output logic [DATA_W-1:0]         rd_word [WORDS]
);
   for (genvar w = 0; w < WORDS; w++) begin : g_word
      for (genvar j = 0; j < PINS_PER_FUNC_WORD; j++) begin : g_slot
         localparam int PIN = w * PINS_PER_FUNC_WORD + j;
         if (PIN < NUM_PINS) begin : g_pin
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)        fields[FIELD_W*PIN +: FIELD_W] <= '0;
               else if (word_we[w]) fields[FIELD_W*PIN +: FIELD_W] <= wdata[FIELD_W*j +: FIELD_W];
            end
            assign rd_word[w][FIELD_W*j +: FIELD_W] = fields[FIELD_W*PIN +: FIELD_W];
         end else begin : g_empty
            assign rd_word[w][FIELD_W*j +: FIELD_W] = '0;
         end
      end
   end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic                      reg_wr,
   input  logic [DATA_W-1:0]         reg_wdata,
   output logic [DATA_W-1:0]         reg_rdata,
   input  logic [NUM_PINS-1:0]       pad_in,
   output logic [NUM_PINS-1:0]       pad_out,
   output logic [NUM_PINS-1:0]       pad_oe,
   output logic [FIELD_W*NUM_PINS-1:0] pin_func,
   output logic                      irq_pin0,
   output logic                      irq_pin1,
   output logic                      irq_shared
);
   localparam int FWORDS = (NUM_PINS + PINS_PER_FUNC_WORD - 1) / PINS_PER_FUNC_WORD;

   if (NUM_PINS < 3 || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("gpio_edge_bank: NUM_PINS must lie in 3..32");
   end

   logic [NUM_PINS-1:0] wmask;
   logic [NUM_PINS-1:0] dir_q, latch_q, rise_q, fall_q;
   logic [NUM_PINS-1:0] lvl, lvl_prev, stat;
   logic [FWORDS-1:0]   func_we;
   logic [DATA_W-1:0]   func_rd [FWORDS];

   assign wmask = reg_wdata[NUM_PINS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         latch_q <= '0;
         rise_q  <= '0;
         fall_q  <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            A_DIR:   dir_q   <= wmask;
            A_SET:   latch_q <= latch_q | wmask;
            A_CLR:   latch_q <= latch_q & ~wmask;
            A_RISE:  rise_q  <= wmask;
            A_FALL:  fall_q  <= wmask;
            default: ;
         endcase
      end
   end

   for (genvar w = 0; w < FWORDS; w++) begin : g_fwe
      assign func_we[w] = reg_wr && (reg_addr == A_FUNC0 + ADDR_W'(w));
   end

   gpio_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(pad_in),
      .sync_now(lvl), .sync_prev(lvl_prev)
   );

   gpio_edge_status #(.WIDTH(NUM_PINS)) u_edge (
      .clk(clk), .rst_n(rst_n), .sync_now(lvl), .sync_prev(lvl_prev),
      .rise_en(rise_q), .fall_en(fall_q),
      .clr_we(reg_wr && reg_addr == A_STAT), .clr_mask(wmask), .status(stat)
   );

   gpio_func_regs #(.NUM_PINS(NUM_PINS)) u_func (
      .clk(clk), .rst_n(rst_n), .word_we(func_we), .wdata(reg_wdata),
      .fields(pin_func), .rd_word(func_rd)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_LEVEL: reg_rdata[NUM_PINS-1:0] = lvl;
         A_DIR:   reg_rdata[NUM_PINS-1:0] = dir_q;
         A_RISE:  reg_rdata[NUM_PINS-1:0] = rise_q;
         A_FALL:  reg_rdata[NUM_PINS-1:0] = fall_q;
         A_STAT:  reg_rdata[NUM_PINS-1:0] = stat;
         default: begin
            for (int w = 0; w < FWORDS; w++)
               if (reg_addr == A_FUNC0 + ADDR_W'(w)) reg_rdata = func_rd[w];
         end
      endcase
   end

   assign pad_out    = latch_q;
   assign pad_oe     = dir_q;
   assign irq_pin0   = stat[0];
   assign irq_pin1   = stat[1];
   assign irq_shared = |stat[NUM_PINS-1:2];
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic                reg_wr,
   input logic [DATA_W-1:0]   reg_wdata,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic                irq_pin0,
   input logic                irq_pin1,
   input logic                irq_shared
);
   AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_SET) |=> ((pad_out & $past(reg_wdata[NUM_PINS-1:0])) == $past(reg_wdata[NUM_PINS-1:0]))); // R1
   AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_SET) |=> ((pad_out & ~$past(reg_wdata[NUM_PINS-1:0])) == ($past(pad_out) & ~$past(reg_wdata[NUM_PINS-1:0])))); // R1
   AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_CLR) |=> ((pad_out & $past(reg_wdata[NUM_PINS-1:0])) == '0)); // R2
   AST_OE_TRACKS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_DIR) |=> (pad_oe == $past(reg_wdata[NUM_PINS-1:0]))); // R3
   AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq_pin0 && !irq_pin1 && !irq_shared && pad_oe == '0 && pad_out == '0)); // R9
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
   .reg_wdata(reg_wdata), .pad_out(pad_out), .pad_oe(pad_oe),
   .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_shared(irq_shared)
);

// File: tb/gpio_edge_bank_test.sv
`timescale 1ns/1ps
module gpio_edge_bank_test;
   localparam int N = 32;
   localparam logic [3:0] A_LEVEL = 0, A_DIR = 1, A_SET = 2, A_CLR = 3,
                          A_RISE = 4, A_FALL = 5, A_STAT = 6, A_FUNC0 = 7;

   logic clk = 0, rst_n = 0;
   logic [3:0] reg_addr = 0;
   logic reg_wr = 0;
   logic [31:0] reg_wdata = 0, reg_rdata;
   logic [N-1:0] pad_in = 0, pad_out, pad_oe;
   logic [2*N-1:0] pin_func;
   logic irq_pin0, irq_pin1, irq_shared;
   int checks = 0, fails = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   gpio_edge_bank uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pin_func(pin_func),
      .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_shared(irq_shared)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #0.5 d = reg_rdata;
   endtask

   task automatic drive_pads(input logic [N-1:0] v);
      @(negedge clk);
      pad_in = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #500000;
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      logic [N-1:0] model;
      logic [N-1:0] bit_p, exp;
      logic [31:0] masks [6];
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R9 reset state
      rd(A_STAT, d); check("R9 status", d, 0);
      rd(A_RISE, d); check("R9 rise", d, 0);
      rd(A_FALL, d); check("R9 fall", d, 0);
      rd(A_DIR, d);  check("R9 dir", d, 0);
      check("R9 out/oe/irq", {pad_out, pad_oe, irq_pin0, irq_pin1, irq_shared}, 0);

      // R1 R2 overlapping set/clear masks
      masks = '{32'hF0F0_00FF, 32'h0FF0_0F0F, 32'h8000_0001, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0};
      model = 0;
      for (int i = 0; i < 6; i++) begin
         wr(A_SET, masks[i]); model = model | masks[i];
         check("R1 set latch", pad_out, model);
         wr(A_CLR, masks[(i + 1) % 6]); model = model & ~masks[(i + 1) % 6];
         check("R2 clear latch", pad_out, model);
      end

      // R3 direction and driver enable
      for (int i = 0; i < 6; i++) begin
         wr(A_DIR, masks[i] ^ 32'h5A5A_A5A5);
         check("R3 oe", pad_oe, masks[i] ^ 32'h5A5A_A5A5);
         rd(A_DIR, d); check("R3 readback", d, masks[i] ^ 32'h5A5A_A5A5);
      end

      // R4 level read, with some pins driving
      for (int i = 0; i < 6; i++) begin
         drive_pads(masks[i] ^ 32'hC3C3_3C3C);
         rd(A_LEVEL, d); check("R4 level", d, masks[i] ^ 32'hC3C3_3C3C);
      end
      drive_pads(0);
      wr(A_STAT, 32'hFFFF_FFFF);

      // R5 R7 every pin, every enable combination
      for (int p = 0; p < N; p++) begin
         bit_p = N'(1) << p;
         for (int m = 0; m < 4; m++) begin
            wr(A_RISE, m[0] ? bit_p : 0);
            wr(A_FALL, m[1] ? bit_p : 0);
            wr(A_STAT, 32'hFFFF_FFFF);
            drive_pads(bit_p);
            exp = m[0] ? bit_p : 0;
            rd(A_STAT, d); check("R5 rising", d, exp);
            check("R7 irq lines", {irq_pin0, irq_pin1, irq_shared}, {exp[0], exp[1], |exp[N-1:2]});
            wr(A_STAT, 32'hFFFF_FFFF);
            drive_pads(0);
            exp = m[1] ? bit_p : 0;
            rd(A_STAT, d); check("R5 falling", d, exp);
            check("R7 irq lines", {irq_pin0, irq_pin1, irq_shared}, {exp[0], exp[1], |exp[N-1:2]});
         end
      end

      // R6 partial write-one-to-clear
      wr(A_STAT, 32'hFFFF_FFFF);
      wr(A_RISE, 32'hFFFF_FFFF);
      wr(A_FALL, 0);
      drive_pads(32'hA5A5_0F03);
      rd(A_STAT, d); check("R6 captured", d, 32'hA5A5_0F03);
      wr(A_STAT, 32'h0000_0F01);
      rd(A_STAT, d); check("R6 partial clear", d, 32'hA5A5_0002);
      wr(A_STAT, d);
      rd(A_STAT, d); check("R6 write-back clear", d, 0);

      // R10 event and clear on the same edge (pin 5, falling)
      wr(A_FALL, 32'h20);
      drive_pads(32'hA5A5_0F23);
      rd(A_STAT, d); check("R10 preset", d, 32'h20);
      @(negedge clk); pad_in[5] = 0;
      @(negedge clk);
      @(negedge clk); reg_addr = A_STAT; reg_wdata = 32'h20; reg_wr = 1;
      @(negedge clk); reg_wr = 0;
      rd(A_STAT, d); check("R10 event wins", d, 32'h20);
      wr(A_STAT, 32'h20);
      rd(A_STAT, d); check("R6 plain clear", d, 0);

      // R8 function fields
      wr(A_FUNC0, 32'hE4E4_1B1B);
      wr(A_FUNC0 + 1, 32'h3C96_5AA5);
      for (int n = 0; n < N; n++) begin
         d = (n < 16) ? 32'hE4E4_1B1B : 32'h3C96_5AA5;
         check("R8 field", pin_func[2*n +: 2], (d >> (2 * (n % 16))) & 3);
      end
      rd(A_FUNC0, d);     check("R8 readback lo", d, 32'hE4E4_1B1B);
      rd(A_FUNC0 + 1, d); check("R8 readback hi", d, 32'h3C96_5AA5);

      finish_run();
   end
endmodule